// File: doc/BRIEF.md
# Window Watchdog Supervisor with Strobed Enable Sampling

This block supervises a host processor. The processor must service the watchdog by driving a falling edge on the service input. If a service is missing or comes too early, the block drives an active-low reset pulse of fixed length.

After power-up, after every reset pulse and after every enable, the watchdog begins in a single long timeout period, and any service inside it is accepted. The first accepted service switches it to window operation. Each window cycle is a closed phase, in which a service counts as a fault, followed by an open phase, in which a service is required. All periods are given in clock ticks.

The enable pin is read through a pull-up control output. While the watchdog, the transceiver enable and the switch enable are all inactive, the pull-up is switched on only for a short slot in each long period. The pin is sampled on the last tick of that slot. Once the pin reads high, or once either of the other enables is active, the pull-up stays on and the pin is followed directly.

Top module: `wdog_supervisor`

## Requirements
- R1: A service is accepted only on a falling edge of `svc_in` that follows at least `MINPW_T` consecutive sampled-high cycles. A shorter high pulse has no effect.
- R2: A rising effective enable starts timeout mode, and so does a re-enable from window mode. If no service is accepted within `TIMEOUT_T` cycles, `rst_out_n` goes low in the cycle after the expiry. A service at any point of timeout mode is accepted.
- R3: An accepted service in timeout mode, or in an open window, starts a closed window of `CLOSED_T` cycles. The closed window is followed by an open window of `OPEN_T` cycles.
- R4: An accepted service during a closed window drives `rst_out_n` low one clock after the service edge is sampled.
- R5: An open window that expires without an accepted service drives `rst_out_n` low exactly `CLOSED_T+OPEN_T` cycles after the service that opened the closed window.
- R6: A reset pulse keeps `rst_out_n` low for exactly `RSTPULSE_T` cycles. The watchdog then restarts in timeout mode, where an immediate service is accepted.
- R7: While the effective enable is low, `rst_out_n` stays high whatever `svc_in` does.
- R8: While `xcvr_en`, `sw_en` and the latched enable are all low, `pullup_on` is high for `PU_ON_T` cycles out of every `PU_PERIOD_T`. `wd_en_pin` is sampled only on the last on-cycle, so a high pin between strobes is not seen.
- R9: Once a strobe samples `wd_en_pin` high, `pullup_on` stays high permanently and the pin is followed directly. A low pin then releases the latch and strobing resumes.
- R10: While `xcvr_en` or `sw_en` is high, `pullup_on` is high continuously.
- R11: After synchronous reset, `rst_out_n` is high and `pullup_on` is high, because strobing begins with an on-slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wd_en_pin | input | 1 | Watchdog enable pin level |
| svc_in | input | 1 | Service input, serviced by a falling edge |
| xcvr_en | input | 1 | Transceiver enable, used only for the low-power condition |
| sw_en | input | 1 | Switch enable, used only for the low-power condition |
| pullup_on | output | 1 | Enable-pin pull-up control |
| rst_out_n | output | 1 | Active-low reset pulse to the host |

## Verification
In continuous mode, the effective enable follows the pin one clock later, and timeout mode starts one clock after that. An expired timeout therefore shows as a low reset `TIMEOUT_T+2` negedges after the pin rises. A service edge is sampled at the next posedge, so an early service shows a low reset at the first negedge after the edge. An expired open window shows a low reset at negedge `CLOSED_T+OPEN_T+1` after the edge. The bench counts negedges from each stimulus and samples one cycle before and at each due point, so an off-by-one in either direction is reported. Pull-up behaviour is checked by counting high samples over whole strobe periods, which does not depend on phase alignment.

// File: rtl/wdog_pkg.sv
// Shared types for the window watchdog supervisor.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package wdog_pkg;

    typedef enum logic [2:0] {
        WD_OFF    = 3'd0,
        WD_TMO    = 3'd1,
        WD_CLOSED = 3'd2,
        WD_OPEN   = 3'd3,
        WD_RST    = 3'd4
    } wd_state_t;

endpackage

// File: rtl/wdog_en_sampler.sv
// Enable-pin sampler: strobes the pull-up while every enable is inactive and
// samples the pin on the last on-cycle; once high (or another enable is
// active) the pull-up stays on and the pin is followed directly.
// Assumes wd_en_pin is already synchronous to clk.
module wdog_en_sampler #(
    parameter int PU_PERIOD_T = 610,
    parameter int PU_ON_T     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_en_pin,
    input  logic xcvr_en,
    input  logic sw_en,
    output logic pullup_on,
    output logic en_eff
);
    localparam int PH_W = $clog2(PU_PERIOD_T + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PU_PERIOD_T - 1);
    localparam logic [PH_W-1:0] PH_SAMP = PH_W'(PU_ON_T - 1);
    localparam logic [PH_W-1:0] PH_ON   = PH_W'(PU_ON_T);

    logic [PH_W-1:0] phase;
    logic            latched;
    logic            en_q;
    logic            cont;

    // continuous pull-up whenever latched or another enable is active
    assign cont = latched | xcvr_en | sw_en;

    // strobe phase, enable latch and effective enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            latched <= 1'b0;
            en_q    <= 1'b0;
        end else if (cont) begin
            phase   <= '0;
            latched <= wd_en_pin;
            en_q    <= wd_en_pin;
        end else begin
            if (phase == PH_SAMP) begin
                en_q    <= wd_en_pin;
                latched <= wd_en_pin;
            end
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
    end

    // pull-up drive: continuous or the on-slot of the strobe
    assign pullup_on = cont | (phase < PH_ON);
    assign en_eff    = en_q;

    AST_EN_SEEN_WITH_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_eff) |-> $past(pullup_on)); // R9

    AST_LATCH_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(wd_en_pin)); // R8

    AST_OTHER_EN_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        (xcvr_en || sw_en) |-> pullup_on); // R10

endmodule

// File: rtl/wdog_svc_filter.sv
// Service qualifier: flags a falling edge of svc_in that follows at least
// MINPW_T consecutive sampled-high cycles. Output is a one-cycle pulse in the
// cycle the low level is first present. Assumes svc_in is synchronous.
module wdog_svc_filter #(
    parameter int MINPW_T = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic svc_in,
    output logic svc_valid
);
    localparam int HC_W = $clog2(MINPW_T + 1);
    localparam logic [HC_W-1:0] HC_MAX = HC_W'(MINPW_T);

    logic [HC_W-1:0] hi_cnt;
    logic            svc_q;

    // saturating high-width counter and previous level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            svc_q  <= 1'b0;
        end else begin
            svc_q <= svc_in;
            if (!svc_in)
                hi_cnt <= '0;
            else if (hi_cnt != HC_MAX)
                hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // qualified falling edge
    assign svc_valid = svc_q & ~svc_in & (hi_cnt == HC_MAX);

    AST_VALID_IS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> ($past(svc_in) && !svc_in)); // R1

endmodule

// File: rtl/wdog_core.sv
// Watchdog state machine: timeout mode after enable or reset pulse, then
// closed/open window cycles; faults give a fixed reset pulse and a restart in
// timeout mode. One shared counter times every state.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_T  = 650,
    parameter int CLOSED_T   = 60,
    parameter int OPEN_T     = 1000,
    parameter int RSTPULSE_T = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_eff,
    input  logic svc_valid,
    output logic rst_out_n
);
    localparam int MAX_A  = (TIMEOUT_T > CLOSED_T) ? TIMEOUT_T : CLOSED_T;
    localparam int MAX_B  = (OPEN_T > RSTPULSE_T) ? OPEN_T : RSTPULSE_T;
    localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] TMO_END = CNT_W'(TIMEOUT_T - 1);
    localparam logic [CNT_W-1:0] CLS_END = CNT_W'(CLOSED_T - 1);
    localparam logic [CNT_W-1:0] OPN_END = CNT_W'(OPEN_T - 1);
    localparam logic [CNT_W-1:0] RST_END = CNT_W'(RSTPULSE_T - 1);

    wd_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // next-state and counter selection
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + 1'b1;
        if (!en_eff) begin
            state_nx = WD_OFF;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                WD_OFF: begin
                    state_nx = WD_TMO;
                    cnt_nx   = '0;
                end
                WD_TMO: begin
                    if (svc_valid) begin
                        state_nx = WD_CLOSED;
                        cnt_nx   = '0;
                    end else if (cnt == TMO_END) begin
                        state_nx = WD_RST;
                        cnt_nx   = '0;
                    end
                end
                WD_CLOSED: begin
                    if (svc_valid) begin
                        state_nx = WD_RST;
                        cnt_nx   = '0;
                    end else if (cnt == CLS_END) begin
                        state_nx = WD_OPEN;
                        cnt_nx   = '0;
                    end
                end
                WD_OPEN: begin
                    if (svc_valid || cnt == OPN_END) begin
                        state_nx = svc_valid ? WD_CLOSED : WD_RST;
                        cnt_nx   = '0;
                    end
                end
                WD_RST: begin
                    if (cnt == RST_END) begin
                        state_nx = WD_TMO;
                        cnt_nx   = '0;
                    end
                end
                default: begin
                    state_nx = WD_OFF;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    // state and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // reset output decoded from the registered state
    assign rst_out_n = (state != WD_RST);

    AST_DISABLED_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff |=> rst_out_n); // R7

    AST_TMO_SVC_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && state == WD_TMO && svc_valid) |=> state == WD_CLOSED); // R3

    AST_EARLY_SVC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && state == WD_CLOSED && svc_valid) |=> !rst_out_n); // R4

    AST_PULSE_THEN_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_out_n) && en_eff) |-> state == WD_TMO); // R6

    AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> ($past(state) == WD_TMO || $past(state) == WD_CLOSED
                             || $past(state) == WD_OPEN)); // R5

endmodule

// File: rtl/wdog_supervisor.sv
// Top level of the window watchdog supervisor: enable-pin sampler, service
// qualifier and watchdog state machine. All times are in clk ticks.
// Assumes all inputs are synchronous to clk.
module wdog_supervisor #(
    parameter int TIMEOUT_T   = 650,
    parameter int CLOSED_T    = 60,
    parameter int OPEN_T      = 1000,
    parameter int RSTPULSE_T  = 80,
    parameter int MINPW_T     = 6,
    parameter int PU_PERIOD_T = 610,
    parameter int PU_ON_T     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_en_pin,
    input  logic svc_in,
    input  logic xcvr_en,
    input  logic sw_en,
    output logic pullup_on,
    output logic rst_out_n
);
    logic en_eff;
    logic svc_valid;

    wdog_en_sampler #(
        .PU_PERIOD_T (PU_PERIOD_T),
        .PU_ON_T     (PU_ON_T)
    ) i_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_en_pin (wd_en_pin),
        .xcvr_en   (xcvr_en),
        .sw_en     (sw_en),
        .pullup_on (pullup_on),
        .en_eff    (en_eff)
    );

    wdog_svc_filter #(
        .MINPW_T (MINPW_T)
    ) i_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .svc_in    (svc_in),
        .svc_valid (svc_valid)
    );

    wdog_core #(
        .TIMEOUT_T  (TIMEOUT_T),
        .CLOSED_T   (CLOSED_T),
        .OPEN_T     (OPEN_T),
        .RSTPULSE_T (RSTPULSE_T)
    ) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_eff    (en_eff),
        .svc_valid (svc_valid),
        .rst_out_n (rst_out_n)
    );

    AST_RST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> $past(en_eff)); // R7

endmodule

// File: tb/test_wdog_supervisor.sv
// Directed bench for wdog_supervisor; one task per scenario.
module test_wdog_supervisor;
    localparam int T  = 650;
    localparam int C  = 60;
    localparam int O  = 1000;
    localparam int RP = 80;
    localparam int MW = 6;
    localparam int PP = 610;
    localparam int PO = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wd_en_pin = 1'b0;
    logic svc_in = 1'b0;
    logic xcvr_en = 1'b0;
    logic sw_en = 1'b0;
    logic pullup_on, rst_out_n;
    int   n_chk = 0;
    int   n_fail = 0;

    always #5 clk = ~clk;

    wdog_supervisor #(
        .TIMEOUT_T(T), .CLOSED_T(C), .OPEN_T(O), .RSTPULSE_T(RP),
        .MINPW_T(MW), .PU_PERIOD_T(PP), .PU_ON_T(PO)
    ) i_wdog_supervisor (
        .clk(clk), .rst_n(rst_n), .wd_en_pin(wd_en_pin), .svc_in(svc_in),
        .xcvr_en(xcvr_en), .sw_en(sw_en), .pullup_on(pullup_on),
        .rst_out_n(rst_out_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count high pullup samples over n negedges
    task automatic count_pu(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pullup_on) hits++;
        end
    endtask

    // count low reset samples over n negedges
    task automatic count_rst(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst_out_n) lows++;
        end
    endtask

    // high for w cycles, then falling edge driven at a negedge
    task automatic service(input int w);
        svc_in = 1'b1;
        wait_n(w);
        svc_in = 1'b0;
    endtask

    // continuous-mode enable: timeout mode established on return
    task automatic enable_wd();
        xcvr_en = 1'b1;
        wd_en_pin = 1'b0;
        wait_n(3);
        wd_en_pin = 1'b1;
        wait_n(2);
    endtask

    task automatic t_reset();
        chk(rst_out_n == 1'b1, "R11 reset rst_out_n", rst_out_n, 1);
        chk(pullup_on == 1'b1, "R11 reset pullup_on", pullup_on, 1);
    endtask

    task automatic t_strobe();
        int h, l;
        count_pu(PP, h);
        chk(h == PO, "R8 strobe duty", h, PO);
        count_pu(2 * PP, h);
        chk(h == 2 * PO, "R8 strobe two periods", h, 2 * PO);
        while (pullup_on) @(negedge clk);
        wd_en_pin = 1'b1;
        wait_n(100);
        wd_en_pin = 1'b0;
        count_pu(PP, h);
        chk(h == PO, "R8 pin high between strobes unseen", h, PO);
        count_rst(50, l);
        chk(l == 0, "R8 no reset while not sampled", l, 0);
    endtask

    task automatic t_latch();
        int h;
        wd_en_pin = 1'b1;
        wait_n(PP + 5);
        count_pu(PP, h);
        chk(h == PP, "R9 pull-up permanent after high sample", h, PP);
        wd_en_pin = 1'b0;
        wait_n(PP + 5);
        count_pu(PP, h);
        chk(h == PO, "R9 strobing resumes after low pin", h, PO);
    endtask

    task automatic t_direct();
        int h;
        sw_en = 1'b1;
        count_pu(PP, h);
        chk(h == PP, "R10 pull-up continuous with sw_en", h, PP);
        sw_en = 1'b0;
    endtask

    task automatic t_timeout();
        int l;
        xcvr_en = 1'b1;
        wd_en_pin = 1'b0;
        wait_n(5);
        wd_en_pin = 1'b1;
        wait_n(T + 1);
        chk(rst_out_n == 1'b1, "R2 high before timeout", rst_out_n, 1);
        wait_n(1);
        chk(rst_out_n == 1'b0, "R2 low at timeout", rst_out_n, 0);
        wait_n(RP - 1);
        chk(rst_out_n == 1'b0, "R6 still low at last pulse cycle", rst_out_n, 0);
        wait_n(1);
        chk(rst_out_n == 1'b1, "R6 released after pulse", rst_out_n, 1);
        wait_n(3);
        service(10);
        count_rst(30, l);
        chk(l == 0, "R6 timeout mode after pulse accepts service", l, 0);
        wd_en_pin = 1'b0;
        wait_n(5);
    endtask

    task automatic t_window();
        int l;
        enable_wd();
        wait_n(20);
        service(10);
        wait_n(C + 50);
        chk(rst_out_n == 1'b1, "R3 high inside open window", rst_out_n, 1);
        service(10);
        count_rst(40, l);
        chk(l == 0, "R3 on-time service accepted", l, 0);
        wait_n(C + O - 40);
        chk(rst_out_n == 1'b1, "R5 high before open expiry", rst_out_n, 1);
        wait_n(1);
        chk(rst_out_n == 1'b0, "R5 low at open expiry", rst_out_n, 0);
        wd_en_pin = 1'b0;
        wait_n(5);
    endtask

    task automatic t_early();
        enable_wd();
        service(10);
        wait_n(10);
        service(10);
        chk(rst_out_n == 1'b1, "R4 high at early edge", rst_out_n, 1);
        wait_n(1);
        chk(rst_out_n == 1'b0, "R4 low after early service", rst_out_n, 0);
        wd_en_pin = 1'b0;
        wait_n(5);
    endtask

    task automatic t_short();
        enable_wd();
        service(10);
        wait_n(5);
        service(MW - 1);
        wait_n(2);
        chk(rst_out_n == 1'b1, "R1 short pulse ignored in closed window", rst_out_n, 1);
        wait_n(C + 20);
        service(MW);
        wait_n(10);
        service(10);
        wait_n(1);
        chk(rst_out_n == 1'b0, "R1 minimum-width pulse accepted", rst_out_n, 0);
        wd_en_pin = 1'b0;
        wait_n(5);
    endtask

    task automatic t_disabled();
        int l;
        xcvr_en = 1'b1;
        wd_en_pin = 1'b0;
        count_rst(T + 200, l);
        chk(l == 0, "R7 no reset while disabled", l, 0);
        enable_wd();
        service(10);
        wait_n(5);
        wd_en_pin = 1'b0;
        wait_n(2);
        service(10);
        count_rst(C + O + 100, l);
        chk(l == 0, "R7 disable mid-window suppresses faults", l, 0);
    endtask

    task automatic t_reenable();
        int l;
        enable_wd();
        service(10);
        wait_n(10);
        wd_en_pin = 1'b0;
        wait_n(3);
        wd_en_pin = 1'b1;
        wait_n(7);
        service(10);
        count_rst(20, l);
        chk(l == 0, "R2 re-enable restarts in timeout mode", l, 0);
        wd_en_pin = 1'b0;
        wait_n(5);
    endtask

    initial begin
        wait_n(4);
        t_reset();
        rst_n = 1'b1;
        t_strobe();
        t_latch();
        t_direct();
        t_timeout();
        t_window();
        t_early();
        t_short();
        t_disabled();
        t_reenable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule